// File: doc/BRIEF.md
# Three-Band Sample Comparator with Hysteresis Events

This block watches a stream of converted samples and places each valid sample into one of three bands, set by a low and a high reference taken from one packed reference word. From the band sequence it derives two independent event outputs. One is a single-cycle trigger pulse meant to drive a fault input of a PWM stage. The other is a sticky interrupt status bit that software clears by writing 1.

Each output has its own 4-bit mode. The mode selects a target band and a firing kind. The kinds are: fire on every sample in the band, fire once on entry to the band, and two hysteresis kinds. The hysteresis kinds fire only after the value has visited the opposite extreme band since the last event. Each output keeps its own history: the previous band, an armed flag and an in-run flag. Each history has its own reset strobe, so stale history can be discarded before a new sequence starts.

Top module: `tri_band_cmp`

## Requirements
- R1: The reference word carries the low reference in bits [9:0] and the high reference in bits [25:16]. A sample at or below the low reference is low band. A sample above the low reference and at or below the high reference is mid band. A sample above the high reference is high band.
- R2: Mode bits [3:2] select the target band: 00 none, 01 low, 10 mid, 11 high. Mode bits [1:0] select the kind: 00 always, 01 once, 10 hysteresis-always, 11 hysteresis-once. Target none never fires. Mid with either hysteresis kind never fires.
- R3: In always mode, every valid sample in the target band produces an event. A cycle without a valid sample produces none.
- R4: In once mode, a sample fires when it is in the target band and the previous valid sample of that output's history was not. After any history reset the previous band is none, so the first in-band sample fires.
- R5: Hysteresis-once fires on entry to the target band only while armed. A sample in the opposite extreme band arms the output. The event and a history reset both disarm it.
- R6: Hysteresis-always fires on every sample of an in-band run that starts while armed. It stops firing as soon as a sample falls outside the band, and it needs a fresh visit to the opposite band to fire again.
- R7: The trigger pulse is high for exactly the one cycle after the clock edge that took the qualifying sample.
- R8: The interrupt status bit sets on the edge that takes a qualifying sample and stays set until irq_clr is pulsed. A new event in the same cycle as a clear leaves the status set.
- R9: The trigger history and the interrupt history are independent. Resetting one does not change how the other responds.
- R10: When a history reset strobe arrives in the same cycle as a valid sample, that output produces no event for the sample and keeps no history from it, including any arming.
- R11: After the synchronous reset, both outputs are low, both histories hold previous band none, and neither output is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 10 | Converted sample value |
| ref_word | input | 32 | Packed references: low in [9:0], high in [25:16] |
| trig_mode | input | 4 | Trigger mode: band [3:2], kind [1:0] |
| irq_mode | input | 4 | Interrupt mode: band [3:2], kind [1:0] |
| trig_hist_rst | input | 1 | Clears trigger history |
| irq_hist_rst | input | 1 | Clears interrupt history |
| irq_clr | input | 1 | Write-1-to-clear for interrupt status |
| trig_pulse | output | 1 | One-cycle trigger event |
| irq_status | output | 1 | Sticky interrupt status |

## Verification
The bench puts samples exactly on both references and one code beyond each. An off-by-one comparison then shows up as the wrong band at a boundary value. In the hysteresis scenarios it walks the value through mid between the extremes and re-enters the target band without a new opposite visit. A design that never disarms, or that lets a mid sample arm it, fires on those repeat entries. It also lands a sample, or a clear, in the same cycle as a history reset or a new event. A wrong priority there shows as a pulse from a discarded sample, an arming that survives the reset, or a status bit lost to the clear.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [1:0] {
    BAND_NONE = 2'd0,
    BAND_LOW  = 2'd1,
    BAND_MID  = 2'd2,
    BAND_HIGH = 2'd3
  } band_e;

  typedef enum logic [1:0] {
    KIND_ALWAYS = 2'd0,
    KIND_ONCE   = 2'd1,
    KIND_HALW   = 2'd2,
    KIND_HONCE  = 2'd3
  } kind_e;

  // extreme band on the far side of a target band; none for mid and none
  function automatic band_e far_band(band_e b);
    case (b)
      BAND_LOW:  return BAND_HIGH;
      BAND_HIGH: return BAND_LOW;
      default:   return BAND_NONE;
    endcase
  endfunction

endpackage

// File: rtl/tbc_classify.sv
module tbc_classify
  import tbc_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic [DW-1:0] smp,
  input  logic [DW-1:0] ref_lo,
  input  logic [DW-1:0] ref_hi,
  output band_e         band
);

  always_comb begin
    if (smp <= ref_lo)      band = BAND_LOW;
    else if (smp <= ref_hi) band = BAND_MID;
    else                    band = BAND_HIGH;
  end

endmodule

// File: rtl/tbc_event.sv
module tbc_event
  import tbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              hist_rst,
  input  band_e             band,
  input  logic [MODE_W-1:0] mode,
  output logic              fire
);

  band_e tgt, opp, prev_q;
  kind_e kind;
  logic  armed_q, run_q;
  logic  in_band, entered, hyst_ok, hit, live;

  assign tgt     = band_e'(mode[MODE_W-1 -: 2]);
  assign kind    = kind_e'(mode[1:0]);
  assign opp     = far_band(tgt);
  assign hyst_ok = (tgt == BAND_LOW) || (tgt == BAND_HIGH);
  assign in_band = (band == tgt);
  assign entered = in_band && (prev_q != tgt);
  assign live    = valid && !hist_rst && (tgt != BAND_NONE);

  always_comb begin
    case (kind)
      KIND_ALWAYS: hit = in_band;
      KIND_ONCE:   hit = entered;
      KIND_HALW:   hit = hyst_ok && in_band && (armed_q || run_q);
      default:     hit = hyst_ok && entered && armed_q;
    endcase
  end

  assign fire = live && hit;

  always_ff @(posedge clk) begin
    if (rst || hist_rst) begin
      prev_q  <= BAND_NONE;
      armed_q <= 1'b0;
      run_q   <= 1'b0;
    end else if (valid) begin
      prev_q <= band;
      if (band == opp)  armed_q <= 1'b1;
      else if (fire)    armed_q <= 1'b0;
      if (fire)         run_q <= 1'b1;
      else if (!in_band) run_q <= 1'b0;
    end
  end

  assert_arm_on_far_R5: assert property (@(posedge clk) disable iff (rst)
    (valid && !hist_rst && (opp != BAND_NONE) && (band == opp)) |=> armed_q);

  assert_hist_clear_R5: assert property (@(posedge clk) disable iff (rst)
    hist_rst |=> ((prev_q == BAND_NONE) && !armed_q && !run_q));

  assert_prev_follows_R4: assert property (@(posedge clk) disable iff (rst)
    (valid && !hist_rst) |=> (prev_q == $past(band)));

  assert_run_ends_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && (band != tgt)) |=> !run_q);

endmodule

// File: rtl/tbc_sticky.sv
module tbc_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    set |=> q);

  assert_clear_takes_R8: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !q);

endmodule

// File: rtl/tri_band_cmp.sv
module tri_band_cmp
  import tbc_pkg::*;
#(
  parameter int DW     = 10,
  parameter int WW     = 32,
  parameter int HI_LSB = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DW-1:0]     smp_data,
  input  logic [WW-1:0]     ref_word,
  input  logic [MODE_W-1:0] trig_mode,
  input  logic [MODE_W-1:0] irq_mode,
  input  logic              trig_hist_rst,
  input  logic              irq_hist_rst,
  input  logic              irq_clr,
  output logic              trig_pulse,
  output logic              irq_status
);

  localparam int NCH     = 2;
  localparam int CH_TRIG = 0;
  localparam int CH_IRQ  = 1;

  logic [DW-1:0] ref_lo, ref_hi;
  band_e         cur_band;
  logic [NCH-1:0][MODE_W-1:0] mode_v;
  logic [NCH-1:0]             hrst_v;
  logic [NCH-1:0]             fire_v;
  logic                       unused_ref_bits;

  assign ref_lo          = ref_word[DW-1:0];
  assign ref_hi          = ref_word[HI_LSB +: DW];
  assign unused_ref_bits = ^ref_word;
  assign mode_v          = {irq_mode, trig_mode};
  assign hrst_v          = {irq_hist_rst, trig_hist_rst};

  tbc_classify #(.DW(DW)) u_cls (
    .smp    (smp_data),
    .ref_lo (ref_lo),
    .ref_hi (ref_hi),
    .band   (cur_band)
  );

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_chan
      tbc_event u_evt (
        .clk      (clk),
        .rst      (rst),
        .valid    (smp_valid),
        .hist_rst (hrst_v[ch]),
        .band     (cur_band),
        .mode     (mode_v[ch]),
        .fire     (fire_v[ch])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) trig_pulse <= 1'b0;
    else     trig_pulse <= fire_v[CH_TRIG];
  end

  tbc_sticky u_irq (
    .clk (clk),
    .rst (rst),
    .set (fire_v[CH_IRQ]),
    .clr (irq_clr),
    .q   (irq_status)
  );

  assert_pulse_has_sample_R10: assert property (@(posedge clk) disable iff (rst)
    trig_pulse |-> $past(smp_valid && !trig_hist_rst));

  assert_none_silent_R2: assert property (@(posedge clk) disable iff (rst)
    trig_pulse |-> $past(trig_mode[MODE_W-1 -: 2] != 2'b00));

  assert_band_match_R3: assert property (@(posedge clk) disable iff (rst)
    trig_pulse |-> $past(cur_band == band_e'(trig_mode[MODE_W-1 -: 2])));

endmodule

// File: tb/tri_band_cmp_test.sv
module tri_band_cmp_test;

  localparam [3:0] M_NONE     = 4'b0000;
  localparam [3:0] LOW_ALW    = 4'b0100;
  localparam [3:0] LOW_ONCE   = 4'b0101;
  localparam [3:0] LOW_HALW   = 4'b0110;
  localparam [3:0] MID_ALW    = 4'b1000;
  localparam [3:0] MID_HALW   = 4'b1010;
  localparam [3:0] HIGH_ALW   = 4'b1100;
  localparam [3:0] HIGH_HONCE = 4'b1111;

  localparam [9:0] VL = 10'd50;
  localparam [9:0] VM = 10'd150;
  localparam [9:0] VH = 10'd250;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_valid = 1'b0;
  logic [9:0] smp_data = '0;
  logic [31:0] ref_word = (32'd200 << 16) | 32'd100;
  logic [3:0] trig_mode = M_NONE;
  logic [3:0] irq_mode = M_NONE;
  logic       trig_hist_rst = 1'b0;
  logic       irq_hist_rst = 1'b0;
  logic       irq_clr = 1'b0;
  logic       trig_pulse, irq_status;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  tri_band_cmp uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .ref_word(ref_word), .trig_mode(trig_mode), .irq_mode(irq_mode),
    .trig_hist_rst(trig_hist_rst), .irq_hist_rst(irq_hist_rst),
    .irq_clr(irq_clr), .trig_pulse(trig_pulse), .irq_status(irq_status)
  );

  task automatic chk(input string rq, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", rq, act, exp);
    end
  endtask

  // drive one cycle of inputs at a falling edge, release at the next one;
  // registered outputs for that cycle are stable at the return
  task automatic step(input logic v, input logic [9:0] d, input logic tr,
                      input logic ir, input logic clr);
    @(negedge clk);
    smp_valid = v; smp_data = d; trig_hist_rst = tr; irq_hist_rst = ir; irq_clr = clr;
    @(negedge clk);
    smp_valid = 1'b0; trig_hist_rst = 1'b0; irq_hist_rst = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic tsamp(input string rq, input logic [9:0] d, input logic exp);
    step(1'b1, d, 1'b0, 1'b0, 1'b0);
    chk(rq, trig_pulse, exp);
  endtask

  task automatic hist_clear();
    step(1'b0, '0, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_reset();
    chk("R11 trig after reset", trig_pulse, 1'b0);
    chk("R11 irq after reset", irq_status, 1'b0);
    trig_mode = LOW_ONCE;
    tsamp("R11 first sample after reset fires", VL, 1'b1);
  endtask

  task automatic t_classify();
    trig_mode = LOW_ALW; hist_clear();
    tsamp("R1 low ref value is low", 10'd100, 1'b1);
    tsamp("R1 low ref plus one not low", 10'd101, 1'b0);
    trig_mode = MID_ALW; hist_clear();
    tsamp("R1 low ref plus one is mid", 10'd101, 1'b1);
    tsamp("R1 high ref is mid", 10'd200, 1'b1);
    tsamp("R1 low ref not mid", 10'd100, 1'b0);
    tsamp("R1 high ref plus one not mid", 10'd201, 1'b0);
    trig_mode = HIGH_ALW; hist_clear();
    tsamp("R1 high ref plus one is high", 10'd201, 1'b1);
    step(1'b0, VH, 1'b0, 1'b0, 1'b0);
    chk("R3 no sample no event", trig_pulse, 1'b0);
    tsamp("R1 high ref not high", 10'd200, 1'b0);
  endtask

  task automatic t_width();
    trig_mode = HIGH_ALW; hist_clear();
    @(negedge clk); smp_valid = 1'b1; smp_data = VH;
    @(negedge clk); smp_valid = 1'b0;
    chk("R7 pulse in cycle after sample", trig_pulse, 1'b1);
    @(negedge clk);
    chk("R7 pulse lasts one cycle", trig_pulse, 1'b0);
  endtask

  task automatic t_none();
    trig_mode = M_NONE; hist_clear();
    tsamp("R2 none mode low", VL, 1'b0);
    tsamp("R2 none mode mid", VM, 1'b0);
    tsamp("R2 none mode high", VH, 1'b0);
    trig_mode = MID_HALW; hist_clear();
    tsamp("R2 mid hysteresis low", VL, 1'b0);
    tsamp("R2 mid hysteresis high", VH, 1'b0);
    tsamp("R2 mid hysteresis mid", VM, 1'b0);
  endtask

  task automatic t_once();
    trig_mode = LOW_ONCE; hist_clear();
    tsamp("R4 first entry", VL, 1'b1);
    tsamp("R4 repeat in band", VL, 1'b0);
    tsamp("R4 leave to mid", VM, 1'b0);
    tsamp("R4 re-entry", VL, 1'b1);
    hist_clear();
    tsamp("R4 after history reset", VL, 1'b1);
  endtask

  task automatic t_hyst_once();
    trig_mode = HIGH_HONCE; hist_clear();
    tsamp("R5 high unarmed", VH, 1'b0);
    tsamp("R5 low arms", VL, 1'b0);
    tsamp("R5 mid passes", VM, 1'b0);
    tsamp("R5 armed entry", VH, 1'b1);
    tsamp("R5 stay in band", VH, 1'b0);
    tsamp("R5 mid after event", VM, 1'b0);
    tsamp("R5 entry without rearm", VH, 1'b0);
    tsamp("R5 low rearms", VL, 1'b0);
    tsamp("R5 direct entry armed", VH, 1'b1);
    tsamp("R5 low arms again", VL, 1'b0);
    step(1'b0, '0, 1'b1, 1'b0, 1'b0);
    tsamp("R5 history reset disarms", VH, 1'b0);
  endtask

  task automatic t_hyst_always();
    trig_mode = LOW_HALW; hist_clear();
    tsamp("R6 low unarmed", VL, 1'b0);
    tsamp("R6 high arms", VH, 1'b0);
    tsamp("R6 armed run start", VL, 1'b1);
    tsamp("R6 run continues", VL, 1'b1);
    tsamp("R6 mid ends run", VM, 1'b0);
    tsamp("R6 no fire without rearm", VL, 1'b0);
  endtask

  task automatic t_irq();
    trig_mode = M_NONE; irq_mode = HIGH_ALW; hist_clear();
    chk("R8 status clear at start", irq_status, 1'b0);
    step(1'b1, VH, 1'b0, 1'b0, 1'b0);
    chk("R8 event sets status", irq_status, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    chk("R8 status sticky", irq_status, 1'b1);
    step(1'b1, VL, 1'b0, 1'b0, 1'b0);
    chk("R8 status sticky past non event", irq_status, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    chk("R8 clear", irq_status, 1'b0);
    step(1'b1, VH, 1'b0, 1'b0, 1'b1);
    chk("R8 event beats clear", irq_status, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    chk("R8 clear again", irq_status, 1'b0);
  endtask

  task automatic t_indep();
    trig_mode = LOW_ONCE; irq_mode = LOW_ONCE; hist_clear();
    step(1'b1, VL, 1'b0, 1'b0, 1'b0);
    chk("R9 trig fires", trig_pulse, 1'b1);
    chk("R9 irq fires", irq_status, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b1, 1'b0, 1'b0);
    step(1'b1, VL, 1'b0, 1'b0, 1'b0);
    chk("R9 trig history reset alone", trig_pulse, 1'b1);
    chk("R9 irq history untouched", irq_status, 1'b0);
  endtask

  task automatic t_collide();
    irq_mode = M_NONE; trig_mode = HIGH_HONCE; hist_clear();
    step(1'b1, VL, 1'b1, 1'b0, 1'b0);
    chk("R10 sample with reset no event", trig_pulse, 1'b0);
    tsamp("R10 arming discarded", VH, 1'b0);
    trig_mode = LOW_ALW;
    step(1'b1, VL, 1'b1, 1'b0, 1'b0);
    chk("R10 always mode sample dropped", trig_pulse, 1'b0);
    trig_mode = LOW_ONCE; hist_clear();
    tsamp("R10 setup entry", VL, 1'b1);
    step(1'b1, VM, 1'b1, 1'b0, 1'b0);
    tsamp("R10 reset sample leaves none history", VL, 1'b1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_classify();
    t_width();
    t_none();
    t_once();
    t_hyst_once();
    t_hyst_always();
    t_irq();
    t_indep();
    t_collide();
    finish_run();
  end

endmodule